// File: doc/BRIEF.md
# Multi-Mode Timer Counter

This block is the timebase of a timer: a counter that steps once for every selected number of enabled input ticks. A two-bit divider picks a ratio of 1, 2, 4 or 8 ticks per step, and a two-bit length field limits the count to 16, 12, 10 or 8 bits. The timer has four modes. Stop freezes the counter. Up counts to a period value taken from channel 0 and then returns to zero. Continuous counts to the maximum of the chosen length. Up/down runs from zero to the period value and back.

A one-cycle clear strobe returns the count, the prescaler and the direction to their start values. The strobe has no stored state, so reading it back always gives zero. A pending-overflow flag is set whenever the count returns to zero through a wrap, or on the way down in up/down mode. The flag stays set until `flag_clr` is pulsed. The interrupt request is the flag gated by its enable input.

Two state machines carry the control. The direction machine has states DIR_UP and DIR_DOWN:
- DIR_UP moves to DIR_DOWN when the count is at or above the period (and not zero) in up/down mode.
- DIR_DOWN moves to DIR_UP when a step brings the count to zero.
- A clear forces DIR_UP, and so does running in up or continuous mode.

The flag machine has states FLG_CLEAR and FLG_PENDING:
- FLG_CLEAR moves to FLG_PENDING on a wrap event.
- FLG_PENDING moves to FLG_CLEAR on `flag_clr` in a cycle with no wrap.

Top module: `tmr_timebase`

## Requirements
- R1: After reset, `count` is 0, `dir_down` is 0, `ovf_flag` is 0 and `irq` is 0.
- R2: `div_sel` values 0, 1, 2 and 3 produce one counter step per 1, 2, 4 and 8 cycles with `tick_en` high. Cycles with `tick_en` low do not advance the prescaler or the count.
- R3: In up mode (`mode_sel`=01), each step adds one. A step taken with the count at or above `period` loads 0 and sets the flag. With `period`=0, the count stays at 0 and every step sets the flag.
- R4: In continuous mode (`mode_sel`=10), the count rises to the length maximum and then wraps to 0 and sets the flag. `period` is ignored. The length maximum is 0xFFFF for `len_sel`=00, 0x0FFF for 01, 0x03FF for 10 and 0x00FF for 11.
- R5: In up/down mode (`mode_sel`=11), the count rises to `period` and then falls, with `dir_down`=1 while falling. A step that brings the falling count to 0 sets the flag and returns `dir_down` to 0. For period P the sequence is 0,1..P,P-1..1,0.
- R6: In stop mode (`mode_sel`=00), the count, the direction and the prescaler phase all hold. Leaving stop mode continues from the held values.
- R7: A cycle with `clr`=1 sets the count to 0, the prescaler phase to 0 and the direction to up at the next edge, whatever the tick or mode. It leaves `ovf_flag` unchanged.
- R8: `ovf_flag` stays set until a cycle with `flag_clr`=1. A wrap in the same cycle as `flag_clr` leaves the flag set.
- R9: `irq` is 1 exactly when `ovf_flag` and `irq_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Input tick qualifier feeding the prescaler |
| mode_sel | input | 2 | 00 stop, 01 up, 10 continuous, 11 up/down |
| len_sel | input | 2 | Counter length: 00 16-bit, 01 12-bit, 10 10-bit, 11 8-bit |
| div_sel | input | 2 | Prescaler ratio 2^div_sel |
| period | input | 16 | Period value from channel 0 |
| clr | input | 1 | Clear strobe for count, prescaler and direction |
| flag_clr | input | 1 | Clears the pending-overflow flag |
| irq_en | input | 1 | Interrupt enable |
| count | output | 16 | Current count |
| dir_down | output | 1 | 1 while counting down |
| ovf_flag | output | 1 | Pending-overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the turning points of the counter.

- The step onto the period in up mode: an off-by-one comparison would give a period of P or P+2 instead of P+1.
- The top of every length in continuous mode: a wrong length mask would wrap early or run past the maximum.
- Both reversals in up/down mode, including a period of 1: a wrong direction update would repeat the peak or go below zero.
- The prescaler phase across stop mode and across clear: if stop lost the phase, or clear kept it, the first step after resuming would come early.
- A wrap in the same cycle as a flag clear: a design that let the clear win would lose an interrupt.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_STOP = 2'b00,
        MODE_UP   = 2'b01,
        MODE_CONT = 2'b10,
        MODE_UPDN = 2'b11
    } tmr_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } tmr_dir_e;

    typedef enum logic {
        FLG_CLEAR   = 1'b0,
        FLG_PENDING = 1'b1
    } tmr_flag_e;
endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick_en,
    input  logic [SEL_W-1:0] div_sel,
    output logic             step
);
    // Largest ratio is 2**(2**SEL_W - 1); the phase counter needs that many bits.
    localparam int PW = (1 << SEL_W) - 1;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] phase_top;

    always_comb begin
        phase_top = ~({PW{1'b1}} << div_sel);
        step      = run && tick_en && (phase_q >= phase_top);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr) begin
            phase_q <= '0;
        end else if (run && tick_en) begin
            if (phase_q >= phase_top) phase_q <= '0;
            else                      phase_q <= phase_q + 1'b1;
        end
    end

    // R2: with a ratio above one, two steps never come in consecutive cycles.
    a_r2_step_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (step && div_sel != '0) |=> !(step && div_sel != '0));
endmodule

// File: rtl/tmr_core.sv
`timescale 1ns/1ps
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  tmr_mode_e     mode,
    input  logic [CW-1:0] lim,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] count,
    output logic          dir_down,
    output logic          wrap
);
    localparam logic [CW-1:0] ONE = CW'(1);

    tmr_dir_e      dir_q, dir_nx;
    logic [CW-1:0] cnt_q, cnt_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= DIR_UP;
            cnt_q <= '0;
        end else begin
            dir_q <= dir_nx;
            cnt_q <= cnt_nx;
        end
    end

    // Next-state and event logic
    always_comb begin
        dir_nx = dir_q;
        cnt_nx = cnt_q;
        wrap   = 1'b0;
        if (clr) begin
            dir_nx = DIR_UP;
            cnt_nx = '0;
        end else if (step) begin
            unique case (mode)
                MODE_STOP: ;
                MODE_UP: begin
                    dir_nx = DIR_UP;
                    if (cnt_q >= period) begin
                        cnt_nx = '0;
                        wrap   = 1'b1;
                    end else begin
                        cnt_nx = cnt_q + ONE;
                    end
                end
                MODE_CONT: begin
                    dir_nx = DIR_UP;
                    if (cnt_q >= lim) begin
                        cnt_nx = '0;
                        wrap   = 1'b1;
                    end else begin
                        cnt_nx = cnt_q + ONE;
                    end
                end
                MODE_UPDN: begin
                    unique case (dir_q)
                        DIR_UP: begin
                            if (cnt_q >= period && cnt_q != '0) begin
                                cnt_nx = cnt_q - ONE;
                                if (cnt_q == ONE) wrap   = 1'b1;
                                else              dir_nx = DIR_DOWN;
                            end else if (cnt_q < period) begin
                                cnt_nx = cnt_q + ONE;
                            end
                        end
                        DIR_DOWN: begin
                            if (cnt_q <= ONE) begin
                                cnt_nx = '0;
                                dir_nx = DIR_UP;
                                wrap   = (cnt_q == ONE);
                            end else begin
                                cnt_nx = cnt_q - ONE;
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        count    = cnt_q;
        dir_down = (dir_q == DIR_DOWN);
    end

    // R7: clear lands at the next edge.
    a_r7_clear_result: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0 && dir_q == DIR_UP));
    // R6: stop mode freezes the count and direction.
    a_r6_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STOP && !clr) |=> ($stable(cnt_q) && $stable(dir_q)));
    // R3: up-mode step at or above period returns to zero.
    a_r3_up_return: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && mode == MODE_UP && cnt_q >= period) |=> cnt_q == '0);
    // R5: the last falling step reaches zero and turns upward.
    a_r5_valley_turn: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && mode == MODE_UPDN && dir_q == DIR_DOWN && cnt_q == ONE)
        |=> (cnt_q == '0 && dir_q == DIR_UP));
endmodule

// File: rtl/tmr_flag.sv
`timescale 1ns/1ps
module tmr_flag
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    tmr_flag_e st_q, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLG_CLEAR;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            FLG_CLEAR:   if (set_evt)              st_nx = FLG_PENDING;
            FLG_PENDING: if (clr_req && !set_evt)  st_nx = FLG_CLEAR;
        endcase
    end

    always_comb flag = (st_q == FLG_PENDING);

    // R8: a wrap always leaves the flag set, even against a clear.
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
    // R8: without a clear request a set flag stays set.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
endmodule

// File: rtl/tmr_timebase.sv
`timescale 1ns/1ps
module tmr_timebase
    import tmr_pkg::*;
#(
    parameter int CW     = 16,
    parameter int LEN_AW = 12,
    parameter int LEN_BW = 10,
    parameter int LEN_CW = 8,
    parameter int SEL_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [1:0]       mode_sel,
    input  logic [1:0]       len_sel,
    input  logic [SEL_W-1:0] div_sel,
    input  logic [CW-1:0]    period,
    input  logic             clr,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic [CW-1:0]    count,
    output logic             dir_down,
    output logic             ovf_flag,
    output logic             irq
);
    localparam logic [CW-1:0] LIM_FULL = '1;
    localparam logic [CW-1:0] LIM_A    = LIM_FULL >> (CW - LEN_AW);
    localparam logic [CW-1:0] LIM_B    = LIM_FULL >> (CW - LEN_BW);
    localparam logic [CW-1:0] LIM_C    = LIM_FULL >> (CW - LEN_CW);

    tmr_mode_e     mode;
    logic [CW-1:0] lim;
    logic          step;
    logic          wrap;

    always_comb begin
        mode = tmr_mode_e'(mode_sel);
        unique case (len_sel)
            2'b00: lim = LIM_FULL;
            2'b01: lim = LIM_A;
            2'b10: lim = LIM_B;
            2'b11: lim = LIM_C;
        endcase
    end

    tmr_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .run     (mode != MODE_STOP),
        .tick_en (tick_en),
        .div_sel (div_sel),
        .step    (step)
    );

    tmr_core #(.CW(CW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .step     (step),
        .mode     (mode),
        .lim      (lim),
        .period   (period),
        .count    (count),
        .dir_down (dir_down),
        .wrap     (wrap)
    );

    tmr_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (wrap),
        .clr_req (flag_clr),
        .flag    (ovf_flag)
    );

    always_comb irq = ovf_flag && irq_en;

    // R4: in continuous mode a step at the length maximum wraps to zero.
    a_r4_cont_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr && mode == MODE_CONT && count == lim) |=> (count == '0 && ovf_flag));
endmodule

// File: tb/test_tmr_timebase.sv
`timescale 1ns/1ps
module test_tmr_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic [1:0]  len_sel = 2'd0;
    logic [1:0]  div_sel = 2'd0;
    logic [15:0] period = 16'd0;
    logic        clr = 1'b0;
    logic        flag_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic [15:0] count;
    logic        dir_down;
    logic        ovf_flag;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_timebase i_tmr_timebase (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_sel(mode_sel),
        .len_sel(len_sel), .div_sel(div_sel), .period(period), .clr(clr),
        .flag_clr(flag_clr), .irq_en(irq_en), .count(count),
        .dir_down(dir_down), .ovf_flag(ovf_flag), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic [1:0]  len;
        logic [1:0]  div;
        logic [15:0] per;
        logic [15:0] ticks;
        logic [15:0] e_cnt;
        logic        e_dir;
        logic        e_flag;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 2'd0, 2'd0, 16'd5,  16'd3,    16'd3,    1'b0, 1'b0}, // R3
        '{2'd1, 2'd0, 2'd0, 16'd5,  16'd6,    16'd0,    1'b0, 1'b1}, // R3
        '{2'd1, 2'd0, 2'd0, 16'd5,  16'd8,    16'd2,    1'b0, 1'b1}, // R3
        '{2'd1, 2'd0, 2'd2, 16'd5,  16'd9,    16'd2,    1'b0, 1'b0}, // R2
        '{2'd1, 2'd0, 2'd3, 16'd5,  16'd16,   16'd2,    1'b0, 1'b0}, // R2
        '{2'd1, 2'd0, 2'd1, 16'd5,  16'd7,    16'd3,    1'b0, 1'b0}, // R2
        '{2'd1, 2'd0, 2'd0, 16'd0,  16'd1,    16'd0,    1'b0, 1'b1}, // R3
        '{2'd2, 2'd3, 2'd0, 16'd0,  16'd255,  16'd255,  1'b0, 1'b0}, // R4
        '{2'd2, 2'd3, 2'd0, 16'd0,  16'd256,  16'd0,    1'b0, 1'b1}, // R4
        '{2'd2, 2'd3, 2'd0, 16'd0,  16'd258,  16'd2,    1'b0, 1'b1}, // R4
        '{2'd2, 2'd2, 2'd0, 16'd0,  16'd1023, 16'd1023, 1'b0, 1'b0}, // R4
        '{2'd2, 2'd2, 2'd0, 16'd0,  16'd1024, 16'd0,    1'b0, 1'b1}, // R4
        '{2'd2, 2'd1, 2'd0, 16'd0,  16'd4096, 16'd0,    1'b0, 1'b1}, // R4
        '{2'd2, 2'd0, 2'd3, 16'd3,  16'd40,   16'd5,    1'b0, 1'b0}, // R4
        '{2'd3, 2'd0, 2'd0, 16'd4,  16'd4,    16'd4,    1'b0, 1'b0}, // R5
        '{2'd3, 2'd0, 2'd0, 16'd4,  16'd5,    16'd3,    1'b1, 1'b0}, // R5
        '{2'd3, 2'd0, 2'd0, 16'd4,  16'd6,    16'd2,    1'b1, 1'b0}, // R5
        '{2'd3, 2'd0, 2'd0, 16'd4,  16'd8,    16'd0,    1'b0, 1'b1}, // R5
        '{2'd3, 2'd0, 2'd0, 16'd4,  16'd9,    16'd1,    1'b0, 1'b1}, // R5
        '{2'd3, 2'd0, 2'd0, 16'd1,  16'd3,    16'd1,    1'b0, 1'b1}, // R5
        '{2'd0, 2'd0, 2'd0, 16'd5,  16'd10,   16'd0,    1'b0, 1'b0}  // R6
    };

    task automatic chk(input string req, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic pulse_clr(input bit also_flag);
        clr = 1'b1;
        flag_clr = also_flag;
        @(negedge clk);
        clr = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic pulse_flag_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic config_set(input logic [1:0] m, input logic [1:0] l,
                              input logic [1:0] d, input logic [15:0] p);
        mode_sel = m;
        len_sel  = l;
        div_sel  = d;
        period   = p;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "count", int'(count), 0);
        chk("R1", "dir_down", int'(dir_down), 0);
        chk("R1", "ovf_flag", int'(ovf_flag), 0);
        chk("R1", "irq", int'(irq), 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            config_set(VECS[i].mode, VECS[i].len, VECS[i].div, VECS[i].per);
            pulse_clr(1'b1);
            ticks(int'(VECS[i].ticks));
            chk("R2-R6 vector", $sformatf("v%0d count", i), int'(count), int'(VECS[i].e_cnt));
            chk("R5 vector", $sformatf("v%0d dir_down", i), int'(dir_down), int'(VECS[i].e_dir));
            chk("R3/R4 vector", $sformatf("v%0d ovf_flag", i), int'(ovf_flag), int'(VECS[i].e_flag));
        end

        // R6: stop holds the count, then resumes from it
        config_set(2'd1, 2'd0, 2'd0, 16'd100);
        pulse_clr(1'b1);
        ticks(10);
        chk("R6", "count before stop", int'(count), 10);
        mode_sel = 2'd0;
        ticks(5);
        chk("R6", "count held in stop", int'(count), 10);
        mode_sel = 2'd1;
        ticks(3);
        chk("R6", "count after resume", int'(count), 13);

        // R6: stop keeps the prescaler phase (2 ticks + 2 ticks = one /4 step)
        config_set(2'd1, 2'd0, 2'd2, 16'd100);
        pulse_clr(1'b1);
        ticks(2);
        mode_sel = 2'd0;
        ticks(5);
        mode_sel = 2'd1;
        ticks(2);
        chk("R6", "prescaler phase kept", int'(count), 1);

        // R6: stop in up/down keeps the falling direction
        config_set(2'd3, 2'd0, 2'd0, 16'd4);
        pulse_clr(1'b1);
        ticks(6);
        mode_sel = 2'd0;
        ticks(4);
        chk("R6", "updn count held", int'(count), 2);
        chk("R6", "updn dir held", int'(dir_down), 1);
        mode_sel = 2'd3;
        ticks(1);
        chk("R6", "updn resumes down", int'(count), 1);

        // R7: clear while falling, with tick_en high in the clear cycle
        config_set(2'd3, 2'd0, 2'd0, 16'd4);
        pulse_clr(1'b1);
        ticks(6);
        tick_en = 1'b1;
        pulse_clr(1'b0);
        tick_en = 1'b0;
        chk("R7", "count after clear", int'(count), 0);
        chk("R7", "dir after clear", int'(dir_down), 0);

        // R7: clear resets the prescaler phase
        config_set(2'd1, 2'd0, 2'd2, 16'd100);
        pulse_clr(1'b1);
        ticks(3);
        pulse_clr(1'b0);
        ticks(3);
        chk("R7", "no step before 4 ticks", int'(count), 0);
        ticks(1);
        chk("R7", "step at 4th tick", int'(count), 1);

        // R8 / R9 flag and interrupt
        config_set(2'd1, 2'd0, 2'd0, 16'd2);
        irq_en = 1'b0;
        pulse_clr(1'b1);
        ticks(3);
        chk("R3", "count wrapped", int'(count), 0);
        chk("R8", "flag set by wrap", int'(ovf_flag), 1);
        chk("R9", "irq masked", int'(irq), 0);
        irq_en = 1'b1;
        @(negedge clk);
        chk("R9", "irq enabled", int'(irq), 1);
        pulse_clr(1'b0);
        chk("R7", "clear keeps flag", int'(ovf_flag), 1);
        repeat (5) @(negedge clk);
        chk("R8", "flag sticky", int'(ovf_flag), 1);
        chk("R2", "no advance without tick", int'(count), 0);
        pulse_flag_clr();
        chk("R8", "flag cleared", int'(ovf_flag), 0);
        chk("R9", "irq drops", int'(irq), 0);
        ticks(2);
        chk("R3", "count at period", int'(count), 2);
        tick_en = 1'b1;
        pulse_flag_clr();
        tick_en = 1'b0;
        chk("R8", "set wins over clear", int'(ovf_flag), 1);
        chk("R3", "wrap with clear", int'(count), 0);
        irq_en = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule